// File: doc/BRIEF.md
# Window-Parallel Pulse Matched Filter

This block correlates a whole window of received samples against a programmable pulse template in one step. A deserializer upstream presents the window as one wide word. In each cycle where `in_valid_i` is high, the block takes that word and computes the template correlation at every lag the window can hold. All lag results come out together, two cycles later.

Template coefficients are written one at a time into a staging bank through a plain write port. The staging bank is copied into the working bank only when a new window is accepted. A running computation therefore never sees a half-written template. Each lag has its own reduction: signed products are folded through a chain of 3:2 carry-save compressors, the redundant sum and carry pair is registered, and one carry-propagate add resolves it at the output.

Top module: `pmf_window`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_data_o` is all zero, and every working and staged coefficient is 0, so a window sent before any write yields all-zero lag results.
- R2: Lag k (0 ≤ k < N_OUT) is output at bits `[k*OW +: OW]` and equals the sum over taps j (0 ≤ j < N_TAPS) of `coef[j] * x[k+j]`. Sample i is input at bits `[i*DW +: DW]`. Samples, coefficients and results are signed two's complement.
- R3: OW = DW + CW + ceil(log2(N_TAPS)). Every lag result is exact, including all-extreme operands such as samples and coefficients all at -2^(DW-1).
- R4: For a window accepted in cycle c, `out_valid_o` is high for exactly one cycle, in cycle c+2. It is low in every cycle that is not two cycles after an accepted window.
- R5: A coefficient write (`coef_we_i` high, tap index on `coef_addr_i`) goes to the staging bank. It reaches the computation only at the next accepted window, and it never alters a window already accepted.
- R6: A coefficient write in the same cycle as `in_valid_i` does not affect that window. It is used from the following window on.
- R7: While `out_valid_o` is low, `out_data_o` holds the last valid result (zero after reset), whatever the inputs do.
- R8: Windows may be accepted in consecutive cycles. Results then appear in consecutive cycles, in order, each with its own coefficients.
- R9: Input samples with index ≥ N_OUT + N_TAPS - 1 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Window clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Accept the window on `in_samples_i` this cycle |
| in_samples_i | input | N_IN*DW | Sample window, sample i at bits `[i*DW +: DW]` |
| coef_we_i | input | 1 | Write one staged coefficient |
| coef_addr_i | input | $clog2(N_TAPS) | Tap index of the write |
| coef_data_i | input | CW | Signed coefficient value |
| out_valid_o | output | 1 | Lag results valid |
| out_data_o | output | N_OUT*OW | Lag results, lag k at bits `[k*OW +: OW]` |

## Verification
Two events can land on the same clock edge: a coefficient write into the staging bank, and the acceptance of a window that copies the staging bank into the working bank. The bench drives a write together with `in_valid_i`. It expects that window to use the staged values from before the write, and the next window to use the new value. Writes are also issued while an accepted window is still in flight, and back-to-back windows are interleaved with writes. Each result is judged against an arithmetic model that tracks the staging contents at the moment of each acceptance.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  function automatic int pmf_out_width(int dw, int cw, int taps);
    return dw + cw + $clog2(taps);
  endfunction

  function automatic int pmf_span(int lags, int taps);
    return lags + taps - 1;
  endfunction

  // largest magnitude a lag sum can reach
  function automatic longint pmf_bound(int dw, int cw, int taps);
    return longint'(taps) * (longint'(1) << (dw - 1)) * (longint'(1) << (cw - 1));
  endfunction

endpackage

// File: rtl/pmf_coef_bank.sv
module pmf_coef_bank #(
  parameter int N_TAPS = 8,
  parameter int CW     = 8,
  localparam int AW    = $clog2(N_TAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        data_i,
  input  logic                 load_i,
  output logic [N_TAPS*CW-1:0] active_o
);

  logic [N_TAPS*CW-1:0] shadow_q;
  logic [N_TAPS*CW-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (we_i) begin
      for (int j = 0; j < N_TAPS; j++) begin
        if (32'(addr_i) == j) shadow_q[j*CW +: CW] <= data_i;
      end
    end
  end

  // copy takes the pre-write staged value on a colliding edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '0;
    else if (load_i) active_q <= shadow_q;
  end

  assign active_o = active_q;

  AST_ACTIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_q)); // R5

  AST_ACTIVE_FROM_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !we_i) |=> (active_q == shadow_q)); // R6

endmodule

// File: rtl/pmf_lag.sv
module pmf_lag
  import pmf_pkg::*;
#(
  parameter int N_TAPS = 8,
  parameter int DW     = 8,
  parameter int CW     = 8,
  localparam int OW    = pmf_out_width(DW, CW, N_TAPS),
  localparam int PW    = DW + CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [N_TAPS*DW-1:0] samp_i,
  input  logic [N_TAPS*CW-1:0] coef_i,
  output logic [OW-1:0]        res_o
);

  localparam longint BOUND = pmf_bound(DW, CW, N_TAPS);

  logic [OW-1:0] prod_w [N_TAPS];
  logic [OW-1:0] sum_w  [N_TAPS];
  logic [OW-1:0] cry_w  [N_TAPS];

  for (genvar j = 0; j < N_TAPS; j++) begin : g_tap
    logic signed [DW-1:0] x;
    logic signed [CW-1:0] w;
    logic signed [PW-1:0] p;
    assign x         = samp_i[j*DW +: DW];
    assign w         = coef_i[j*CW +: CW];
    assign p         = x * w;
    assign prod_w[j] = {{(OW-PW){p[PW-1]}}, p};
  end

  // 3:2 compressor chain, carry kept redundant until the output
  assign sum_w[0] = prod_w[0];
  assign cry_w[0] = '0;
  for (genvar j = 1; j < N_TAPS; j++) begin : g_csa
    assign sum_w[j] = sum_w[j-1] ^ cry_w[j-1] ^ prod_w[j];
    assign cry_w[j] = ((sum_w[j-1] & cry_w[j-1]) |
                       (sum_w[j-1] & prod_w[j])  |
                       (cry_w[j-1] & prod_w[j])) << 1;
  end

  logic [OW-1:0] sum_q, cry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cry_q <= '0;
    end else if (en_i) begin
      sum_q <= sum_w[N_TAPS-1];
      cry_q <= cry_w[N_TAPS-1];
    end
  end

  assign res_o = sum_q + cry_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'($signed(res_o)) <= BOUND) && (longint'($signed(res_o)) >= -BOUND)); // R3

endmodule

// File: rtl/pmf_window.sv
module pmf_window
  import pmf_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 8,
  parameter int N_TAPS = 8,
  parameter int DW     = 8,
  parameter int CW     = 8,
  localparam int AW    = $clog2(N_TAPS),
  localparam int OW    = pmf_out_width(DW, CW, N_TAPS),
  localparam int SPAN  = pmf_span(N_OUT, N_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [N_IN*DW-1:0]  in_samples_i,
  input  logic                coef_we_i,
  input  logic [AW-1:0]       coef_addr_i,
  input  logic [CW-1:0]       coef_data_i,
  output logic                out_valid_o,
  output logic [N_OUT*OW-1:0] out_data_o
);

  logic [N_TAPS*CW-1:0] coef_w;
  logic                 s1_valid_q, s2_valid_q;
  logic [SPAN*DW-1:0]   s1_samp_q;

  pmf_coef_bank #(.N_TAPS(N_TAPS), .CW(CW)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (coef_we_i),
    .addr_i  (coef_addr_i),
    .data_i  (coef_data_i),
    .load_i  (in_valid_i),
    .active_o(coef_w)
  );

  // only the samples some lag reaches are stored
  if (N_IN > SPAN) begin : g_tail
    logic unused_tail;
    assign unused_tail = ^in_samples_i[N_IN*DW-1:SPAN*DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s1_samp_q  <= '0;
    end else begin
      s1_valid_q <= in_valid_i;
      s2_valid_q <= s1_valid_q;
      if (in_valid_i) s1_samp_q <= in_samples_i[SPAN*DW-1:0];
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_lag
    pmf_lag #(.N_TAPS(N_TAPS), .DW(DW), .CW(CW)) u_lag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (s1_valid_q),
      .samp_i(s1_samp_q[k*DW +: N_TAPS*DW]),
      .coef_i(coef_w),
      .res_o (out_data_o[k*OW +: OW])
    );
  end

  assign out_valid_o = s2_valid_q;

  AST_LATENCY_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o); // R4

  AST_LATENCY_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o); // R4

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_q |=> $stable(out_data_o)); // R7

endmodule

// File: tb/pmf_window_tb.sv
module pmf_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 16;
  localparam int N_OUT  = 8;
  localparam int N_TAPS = 8;
  localparam int DW     = 8;
  localparam int CW     = 8;
  localparam int AW     = $clog2(N_TAPS);
  localparam int OW     = DW + CW + $clog2(N_TAPS);

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                in_valid = 1'b0;
  logic [N_IN*DW-1:0]  in_samples = '0;
  logic                coef_we = 1'b0;
  logic [AW-1:0]       coef_addr = '0;
  logic [CW-1:0]       coef_data = '0;
  logic                out_valid;
  logic [N_OUT*OW-1:0] out_data;

  pmf_window #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TAPS(N_TAPS), .DW(DW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_samples_i(in_samples),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int stage_m [N_TAPS];
  int samp [N_IN];
  int held [N_OUT];
  bit    pv_a, pv_b;
  int    pe_a [N_OUT];
  int    pe_b [N_OUT];
  string pt_a, pt_b;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model pipeline, check the output
  task automatic tick(bit v, bit we, int addr, int data, string tag);
    int ne [N_OUT];
    in_valid = v;
    coef_we  = we;
    coef_addr = AW'(addr);
    coef_data = CW'(data);
    for (int i = 0; i < N_IN; i++) in_samples[i*DW +: DW] = DW'(samp[i]);
    for (int k = 0; k < N_OUT; k++) begin
      ne[k] = 0;
      for (int j = 0; j < N_TAPS; j++) ne[k] += stage_m[j] * samp[k+j];
    end
    if (we) stage_m[addr] = data;
    @(negedge clk);
    pv_b = pv_a; pe_b = pe_a; pt_b = pt_a;
    pv_a = v;    pe_a = ne;   pt_a = tag;
    check(out_valid == pv_b, "R4", "out_valid", int'(out_valid), int'(pv_b));
    for (int k = 0; k < N_OUT; k++) begin
      int act;
      act = int'($signed(out_data[k*OW +: OW]));
      if (pv_b) begin
        held[k] = pe_b[k];
        check(act == pe_b[k], pt_b, $sformatf("lag %0d", k), act, pe_b[k]);
      end else begin
        check(act == held[k], "R7", $sformatf("hold lag %0d", k), act, held[k]);
      end
    end
  endtask

  task automatic rand_samples();
    for (int i = 0; i < N_IN; i++) samp[i] = int'($urandom_range(0, 255)) - 128;
  endtask

  task automatic load_all(int val);
    for (int j = 0; j < N_TAPS; j++) tick(1'b0, 1'b1, j, val, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N_TAPS; j++) stage_m[j] = 0;
    for (int k = 0; k < N_OUT; k++) begin held[k] = 0; pe_a[k] = 0; pe_b[k] = 0; end
    for (int i = 0; i < N_IN; i++) samp[i] = 0;
    pv_a = 0; pv_b = 0; pt_a = "R2"; pt_b = "R2";
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
    check(out_data == '0, "R1", "reset data nonzero", int'(out_data != '0), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: coefficients start at zero
    rand_samples();
    tick(1'b1, 1'b0, 0, 0, "R1");
    tick(1'b0, 1'b0, 0, 0, "R7");
    tick(1'b0, 1'b0, 0, 0, "R7");

    // R2/R5: load a template, then write while the window is in flight
    for (int j = 0; j < N_TAPS; j++)
      tick(1'b0, 1'b1, j, int'($urandom_range(0, 255)) - 128, "R5");
    rand_samples();
    tick(1'b1, 1'b0, 0, 0, "R2");
    tick(1'b0, 1'b1, 2, 77, "R5");
    tick(1'b0, 1'b1, 5, -90, "R5");
    rand_samples();
    tick(1'b1, 1'b0, 0, 0, "R5");
    tick(1'b0, 1'b0, 0, 0, "R7");
    rand_samples();
    tick(1'b0, 1'b0, 0, 0, "R7");

    // R2: random sweep with sparse writes and gaps
    for (int w = 0; w < 60; w++) begin
      int nw;
      nw = int'($urandom_range(0, 3));
      for (int q = 0; q < nw; q++)
        tick(1'b0, 1'b1, int'($urandom_range(0, N_TAPS-1)), int'($urandom_range(0, 255)) - 128, "R5");
      rand_samples();
      tick(1'b1, 1'b0, 0, 0, "R2");
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) tick(1'b0, 1'b0, 0, 0, "R7");
    end

    // R3: extreme operands
    load_all(-128);
    for (int i = 0; i < N_IN; i++) samp[i] = -128;
    tick(1'b1, 1'b0, 0, 0, "R3");
    for (int i = 0; i < N_IN; i++) samp[i] = 127;
    tick(1'b1, 1'b0, 0, 0, "R3");
    load_all(127);
    for (int i = 0; i < N_IN; i++) samp[i] = -128;
    tick(1'b1, 1'b0, 0, 0, "R3");
    for (int i = 0; i < N_IN; i++) samp[i] = (i % 2 == 0) ? 127 : -128;
    tick(1'b1, 1'b0, 0, 0, "R3");
    tick(1'b0, 1'b0, 0, 0, "R7");
    tick(1'b0, 1'b0, 0, 0, "R7");

    // R6: write colliding with acceptance
    for (int r = 0; r < 8; r++) begin
      rand_samples();
      tick(1'b1, 1'b1, r % N_TAPS, int'($urandom_range(0, 255)) - 128, "R6");
      rand_samples();
      tick(1'b1, 1'b0, 0, 0, "R6");
      tick(1'b0, 1'b0, 0, 0, "R7");
    end

    // R8: back-to-back windows, some with writes
    for (int b = 0; b < 12; b++) begin
      rand_samples();
      tick(1'b1, b[0], int'($urandom_range(0, N_TAPS-1)), int'($urandom_range(0, 255)) - 128, "R8");
    end
    tick(1'b0, 1'b0, 0, 0, "R7");
    tick(1'b0, 1'b0, 0, 0, "R7");

    // R9: top sample index is beyond every lag's reach
    rand_samples();
    samp[N_IN-1] = 127;
    tick(1'b1, 1'b0, 0, 0, "R9");
    samp[N_IN-1] = -128;
    tick(1'b1, 1'b0, 0, 0, "R9");
    samp[N_IN-1] = 0;
    tick(1'b1, 1'b0, 0, 0, "R9");
    tick(1'b0, 1'b0, 0, 0, "R7");
    rand_samples();
    tick(1'b0, 1'b0, 0, 0, "R7");
    tick(1'b0, 1'b0, 0, 0, "R7");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule